// File: doc/BRIEF.md
# Audio Serial-Port Clock Generator

This block derives the bit clock and the left/right frame clock of a stereo audio serial port from a single master clock. The logic runs on `clk`, a sampling clock at twice the master-clock rate, so both master-clock edges are available to it. A quarter-cycle of the master clock is therefore never needed. A fractional prescale of 1.5 master periods is then three `clk` cycles, and a prescale of 3 master periods is six.

A 2-bit mode input picks one of three clock-master speeds or a slave setting in which the generator is quiet. A prescale select is latched from `pre_fast_i` under reset or on a `cfg_load_i` strobe. The select is 1 for the fast master-clock ratios and 0 for the slow ones. Each speed then divides the prescaled tick to give 64 bit clocks per frame. Besides the two clocks, the block emits single-cycle marks of the bit-clock edges for a downstream data shifter, and an output-enable that is low in slave mode.

Whenever the mode or the latched select changes, every divider restarts from zero. The next frame then opens with its left half.

Top module: `audio_clkgen`

## Requirements
- R1: `mode_i` encodes 00 = master single speed, 01 = master double speed, 10 = master quad speed, 11 = slave. In slave mode `clk_oe_o`, `sclk_o`, `lrck_o` and both edge marks are held low.
- R2: The prescale select is taken from `pre_fast_i` only while `rst` is high or in a cycle with `cfg_load_i` high. A change of `pre_fast_i` without a strobe has no effect on the output clocks.
- R3: One frame (`lrck_o` period) lasts 384, 192 or 96 master-clock periods with the slow select (0) and 768, 384 or 192 with the fast select (1), in single, double and quad speed respectively. One master-clock period is two `clk` cycles.
- R4: Every frame holds exactly 64 bit-clock periods. A bit-clock period is 4, 2 or 1 prescaled ticks in single, double and quad speed, where a tick is 3 `clk` cycles (select 0) or 6 (select 1).
- R5: `sclk_o` is high for half of its period in single and double speed and for one third of it in quad speed.
- R6: `lrck_o` is high for exactly half of each frame and changes only in a cycle where `sclk_o` falls.
- R7: After reset, or after a change of `mode_i` or of the latched select, all dividers restart. `sclk_o` and `lrck_o` are low by the second `clk` edge after the change. The first frame then starts with 32 bit clocks at `lrck_o` low (left half).
- R8: `sclk_rise_o` is high for exactly the cycles in which `sclk_o` has just gone from 0 to 1. `sclk_fall_o` is high for exactly the cycles in which it has just gone from 1 to 0.
- R9: Right after reset is released, `sclk_o` and `lrck_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at twice the master-clock rate |
| rst | input | 1 | Synchronous active-high reset; also latches the prescale select |
| mode_i | input | 2 | Speed / master-slave selection |
| pre_fast_i | input | 1 | Prescale select: 1 = divide by 3, 0 = divide by 1.5 |
| cfg_load_i | input | 1 | Strobe that loads `pre_fast_i` |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock, low = left channel |
| sclk_rise_o | output | 1 | One-cycle mark of a bit-clock rising edge |
| sclk_fall_o | output | 1 | One-cycle mark of a bit-clock falling edge |
| clk_oe_o | output | 1 | Output enable of the two clocks, low in slave mode |

## Verification
The assertions assume that `rst` is high from time zero for at least two cycles. They also assume that `mode_i`, `pre_fast_i` and `cfg_load_i` change only between `clk` edges, so that the one-cycle restart window after a change is seen by every check that excludes it. The bench drives all inputs on the falling edge of `clk`. It holds each configuration for longer than one full frame, and it gives each mode or select change two edges to settle before it measures the outputs.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // clk cycles per prescaled tick for the divide-by-1.5 select (clk = 2x master)
  parameter int SLOW_PRE    = 3;
  parameter int FAST_PRE    = 2 * SLOW_PRE;
  // prescaled ticks per bit clock in single speed; halves per faster speed
  parameter int SINGLE_BDIV = 4;

  localparam int MAX_PER = FAST_PRE * SINGLE_BDIV;
  localparam int PER_W   = $clog2(MAX_PER + 1);

  typedef enum logic [1:0] {
    M_SINGLE = 2'b00,
    M_DOUBLE = 2'b01,
    M_QUAD   = 2'b10,
    M_SLAVE  = 2'b11
  } mode_e;

  function automatic int pre_ticks(logic fast);
    return fast ? FAST_PRE : SLOW_PRE;
  endfunction

  // bit-clock period in clk cycles
  function automatic logic [PER_W-1:0] bit_period(mode_e m, logic fast);
    int p;
    case (m)
      M_SINGLE: p = pre_ticks(fast) * SINGLE_BDIV;
      M_DOUBLE: p = pre_ticks(fast) * (SINGLE_BDIV / 2);
      default:  p = pre_ticks(fast) * (SINGLE_BDIV / 4);
    endcase
    return PER_W'(p);
  endfunction

  // bit-clock high time in clk cycles
  function automatic logic [PER_W-1:0] bit_high(mode_e m, logic fast);
    int h;
    if (m == M_QUAD) h = pre_ticks(fast) / 3;
    else             h = int'(bit_period(m, fast)) / 2;
    return PER_W'(h);
  endfunction

endpackage

// File: rtl/audio_clk_cfg.sv
module audio_clk_cfg
  import audio_clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       pre_fast_i,
  input  logic       cfg_load_i,
  output mode_e      mode_r,
  output logic       fast_r,
  output logic       restart_r
);

  logic mode_chg;
  logic sel_chg;

  assign mode_chg = (mode_e'(mode_i) != mode_r);
  assign sel_chg  = cfg_load_i && (pre_fast_i != fast_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r    <= mode_e'(mode_i);
      fast_r    <= pre_fast_i;
      restart_r <= 1'b1;
    end else begin
      mode_r    <= mode_e'(mode_i);
      if (cfg_load_i) fast_r <= pre_fast_i;
      restart_r <= mode_chg || sel_chg;
    end
  end

  // R2: the select only moves on a strobe
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_load_i)) |-> $stable(fast_r));

  // R7: a select change through the strobe always schedules a restart
  a_r7_sel_restart: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(fast_r)) |-> restart_r);

endmodule

// File: rtl/audio_bit_timer.sv
module audio_bit_timer
  import audio_clkgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_r,
  input  logic  fast_r,
  input  logic  restart,
  output logic  sclk_q,
  output logic  rise_q,
  output logic  fall_q,
  output logic  step,
  output logic  clr
);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] cnt_nxt;
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] hi;
  logic [PER_W-1:0] rise_at;
  logic             wrap;

  always_comb begin
    per     = bit_period(mode_r, fast_r);
    hi      = bit_high(mode_r, fast_r);
    rise_at = per - hi;
    clr     = restart || (mode_r == M_SLAVE);
    wrap    = (cnt == per - PER_W'(1));
    step    = !clr && wrap;
    if (clr)       cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      sclk_q <= (cnt_nxt >= rise_at);
      rise_q <= (cnt_nxt == rise_at);
      fall_q <= wrap;
    end
  end

  // R4: the position counter stays inside the current bit period
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst || restart)
    cnt < per);

endmodule

// File: rtl/audio_frame_ctr.sv
module audio_frame_ctr #(
  parameter int FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic lrck_q
);

  localparam int BC_W = $clog2(FRAME_BITS);

  logic [BC_W-1:0] bit_cnt;
  logic [BC_W-1:0] bit_nxt;

  always_comb begin
    if (clr)       bit_nxt = '0;
    else if (step) bit_nxt = bit_cnt + BC_W'(1);
    else           bit_nxt = bit_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      lrck_q  <= 1'b0;
    end else begin
      bit_cnt <= bit_nxt;
      lrck_q  <= bit_nxt[BC_W-1];
    end
  end

  // R7: a cleared divider always restarts in the left half
  a_r7_left_first: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lrck_q);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       pre_fast_i,
  input  logic       cfg_load_i,
  output logic       sclk_o,
  output logic       lrck_o,
  output logic       sclk_rise_o,
  output logic       sclk_fall_o,
  output logic       clk_oe_o
);

  mode_e mode_r;
  logic  fast_r;
  logic  restart_r;
  logic  step;
  logic  clr;

  audio_clk_cfg i_cfg (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .pre_fast_i (pre_fast_i),
    .cfg_load_i (cfg_load_i),
    .mode_r     (mode_r),
    .fast_r     (fast_r),
    .restart_r  (restart_r)
  );

  audio_bit_timer i_bit (
    .clk     (clk),
    .rst     (rst),
    .mode_r  (mode_r),
    .fast_r  (fast_r),
    .restart (restart_r),
    .sclk_q  (sclk_o),
    .rise_q  (sclk_rise_o),
    .fall_q  (sclk_fall_o),
    .step    (step),
    .clr     (clr)
  );

  audio_frame_ctr #(.FRAME_BITS(FRAME_BITS)) i_frame (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .step   (step),
    .lrck_q (lrck_o)
  );

  always_ff @(posedge clk) begin
    if (rst) clk_oe_o <= 1'b0;
    else     clk_oe_o <= (mode_r != M_SLAVE);
  end

  // R1: slave mode keeps every output quiet
  a_r1_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_r == M_SLAVE) |=> (!sclk_o && !lrck_o && !clk_oe_o && !sclk_rise_o));

  // R6: the frame clock moves only together with a bit-clock fall
  a_r6_lrck_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && $changed(lrck_o)) |-> $fell(sclk_o));

  // R8: edge marks coincide with the edges they mark
  a_r8_rise_mark: assert property (@(posedge clk) disable iff (rst)
    sclk_rise_o |-> (sclk_o && !$past(sclk_o)));

  a_r8_fall_mark: assert property (@(posedge clk) disable iff (rst)
    sclk_fall_o |-> (!sclk_o && $past(sclk_o)));

endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic       pre_fast_i = 1'b0;
  logic       cfg_load_i = 1'b0;
  logic       sclk_o, lrck_o, sclk_rise_o, sclk_fall_o, clk_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  audio_clkgen i_audio_clkgen (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .pre_fast_i  (pre_fast_i),
    .cfg_load_i  (cfg_load_i),
    .sclk_o      (sclk_o),
    .lrck_o      (lrck_o),
    .sclk_rise_o (sclk_rise_o),
    .sclk_fall_o (sclk_fall_o),
    .clk_oe_o    (clk_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // master-clock periods per frame, from the ratio table
  function automatic int exp_ratio(int m, bit fast);
    int base;
    base = (m == 0) ? 384 : (m == 1) ? 192 : 96;
    return fast ? 2 * base : base;
  endfunction

  task automatic measure(int m, bit fast, bit fresh, string tag);
    int pre, per, hi;
    int r1 = -1, r2 = -1, f1 = -1, lt1 = -1, lt2 = -1, lf1 = -1;
    int nfall_pre = 0, nrise = 0;
    bit ps, pl, s, l, re, fe;
    bit pulse_bad = 0, lr_bad = 0;
    pre = fast ? 6 : 3;
    per = pre * ((m == 0) ? 4 : (m == 1) ? 2 : 1);
    hi  = (m == 2) ? pre / 3 : per / 2;
    @(negedge clk);
    ps = sclk_o; pl = lrck_o;
    for (int t = 1; t < 5000 && lt2 < 0; t++) begin
      @(negedge clk);
      s = sclk_o; l = lrck_o; re = sclk_rise_o; fe = sclk_fall_o;
      if (re != (s && !ps)) pulse_bad = 1;
      if (fe != (!s && ps)) pulse_bad = 1;
      if (l != pl && !(ps && !s)) lr_bad = 1;
      if (s && !ps) begin
        if (r1 < 0) r1 = t; else if (r2 < 0) r2 = t;
        if (lt1 >= 0) nrise++;
      end
      if (!s && ps) begin
        if (r1 >= 0 && f1 < 0) f1 = t;
        if (lt1 < 0) nfall_pre++;
      end
      if (l && !pl) begin
        if (lt1 < 0) lt1 = t; else lt2 = t;
      end
      if (!l && pl && lt1 >= 0 && lf1 < 0) lf1 = t;
      ps = s; pl = l;
    end
    $display("%s: mode %0d fast %0d frame %0d clk", tag, m, fast, lt2 - lt1);
    // R3: master periods per frame (two clk cycles per master period)
    check(lt2 > 0 && (lt2 - lt1) == 2 * exp_ratio(m, fast), "R3 frame ratio",
          (lt2 - lt1) / 2, exp_ratio(m, fast));
    // R4: bit period and 64 bits per frame
    check(r2 > 0 && (r2 - r1) == per, "R4 bit period", r2 - r1, per);
    check(nrise == 64, "R4 bits per frame", nrise, 64);
    // R5: bit-clock high time
    check(f1 > 0 && (f1 - r1) == hi, "R5 sclk high time", f1 - r1, hi);
    // R6: frame high half and edge alignment
    check(lf1 > 0 && (lf1 - lt1) == 32 * per, "R6 lrck high half", lf1 - lt1, 32 * per);
    check(!lr_bad, "R6 lrck only on sclk fall", lr_bad, 0);
    // R8: edge marks
    check(!pulse_bad, "R8 edge marks", pulse_bad, 0);
    // R7: first frame opens with 32 left bits
    if (fresh) check(nfall_pre == 32, "R7 left half first", nfall_pre, 32);
  endtask

  task automatic reset_with(int m, bit fast);
    @(negedge clk);
    rst = 1'b1; mode_i = 2'(m); pre_fast_i = fast;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet right after reset
    check(sclk_o == 0 && lrck_o == 0, "R9 reset state", {sclk_o, lrck_o}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      for (int f = 0; f < 2; f++) begin
        reset_with(m, f[0]);
        check(clk_oe_o == 1, "R1 master enables outputs", clk_oe_o, 1);
        measure(m, f[0], 1'b1, "sweep");
      end
    end

    // R7: mode change restarts the dividers (quad fast -> single fast)
    mode_i = 2'b00;
    @(negedge clk);
    @(negedge clk);
    check(sclk_o == 0 && lrck_o == 0, "R7 quiet after mode change", {sclk_o, lrck_o}, 0);
    measure(0, 1'b1, 1'b1, "mode change");

    // R2: select change without strobe is ignored
    pre_fast_i = 1'b0;
    measure(0, 1'b1, 1'b0, "no strobe");

    // R2/R7: strobe loads the new select and restarts
    cfg_load_i = 1'b1;
    @(negedge clk);
    cfg_load_i = 1'b0;
    @(negedge clk);
    check(sclk_o == 0 && lrck_o == 0, "R7 quiet after select load", {sclk_o, lrck_o}, 0);
    measure(0, 1'b0, 1'b1, "strobe");

    // R1: slave mode silences everything
    mode_i = 2'b11;
    repeat (3) @(negedge clk);
    begin
      bit loud = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (sclk_o || lrck_o || clk_oe_o || sclk_rise_o || sclk_fall_o) loud = 1;
      end
      check(!loud, "R1 slave quiet", loud, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule